// File: doc/BRIEF.md
# Credit-Counting Interrupt Coalescer

This block raises one level interrupt for a single device queue. Each hardware event pulse adds one credit to a count of unacknowledged work. While that count is nonzero, a programmable coalescing timer runs in core clock cycles. The interrupt line goes high once the timer reaches its limit, as long as the line is not masked. The timer has two modes. In the first it measures from the first pending event. In the second every new event starts the wait again, so the interrupt fires only after a quiet gap.

Software controls the block through a small word-addressed register port. To acknowledge work it writes one credit-return word. That word subtracts a number of credits and can also clear the mask and restart the timer in the same write. An optional automatic mask sets the mask bit in the same cycle that the interrupt rises, so each assertion is seen only once until software re-arms it. A separate pending output stays high for as long as credits remain. It serves shared-line polling, and reading it never clears it.

Top module: `ircx_ctrl`

## Requirements
- R1: After reset the credit count, elapsed timer, delay limit, mode, automatic-mask enable and mask are all zero, and `irq_o` and `pend_o` are low.
- R2: Registers sit at byte offsets 0x00 delay limit (bits 15:0), 0x08 elapsed timer (read-only), 0x10 mode (bit 0), 0x18 automatic-mask enable (bit 0), 0x20 mask (bit 0), 0x28 credit count (read-only) and 0x30 credit return (write-only, reads 0). Any other offset reads 0, writes to read-only offsets change nothing, and read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: Each cycle with `evt_pulse` high adds one credit. The count saturates at 0xFFFF.
- R4: A credit-return write subtracts bits [15:0] from the count and clamps at zero. When an event arrives in the same cycle, the result is old + 1 − returned, clamped to the range 0 to 0xFFFF.
- R5: Reading the credit count leaves it unchanged.
- R6: In absolute mode (mode bit 0 = 0) with delay limit L and the mask clear, `irq_o` rises L+1 cycles after the edge that takes the count from zero to nonzero. Later events do not move that point.
- R7: In quiet mode (mode bit 0 = 1) every event restarts the timer, so `irq_o` rises L+1 cycles after the most recent event.
- R8: `irq_o` is high only while credits are nonzero, the mask is clear and the timer has reached its limit. It falls one cycle after the mask is set or after the count reaches zero.
- R9: A credit-return write with bit 16 set clears the mask.
- R10: A credit-return write with bit 17 set restarts the coalescing timer from zero.
- R11: With the automatic mask enabled, the mask bit becomes 1 on the same edge that `irq_o` rises. A register write to the mask in that cycle takes priority.
- R12: `pend_o` is high exactly while the credit count is nonzero. Register reads do not clear it.
- R13: Reading offset 0x08 returns the number of edges counted since the timer last restarted. A read issued m edges after the first event returns m−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| evt_pulse | input | 1 | One credit per cycle high |
| irq_o | output | 1 | Level interrupt, registered |
| pend_o | output | 1 | Pending view, high while credits remain |

## Verification
The hardest case to reach from the ports is the top of the credit range, together with an event and a return landing on the same edge. To reach it, the bench holds the event input high for more than 65,535 cycles and then fires a combined event-and-return cycle against the saturated count. The second hard case is the exact rise cycle of the interrupt. The bench sweeps the delay limit over both timer modes with single and double events, and restarts the timer mid-wait through the return word. For each case it counts edges from the triggering write or event to the rising interrupt.

// File: rtl/ircx_pkg.sv
package ircx_pkg;

  typedef enum logic [2:0] {
    RI_DELAY    = 3'd0,
    RI_ELAPSED  = 3'd1,
    RI_MODE     = 3'd2,
    RI_AUTOMASK = 3'd3,
    RI_MASK     = 3'd4,
    RI_CREDITS  = 3'd5,
    RI_RETURN   = 3'd6,
    RI_NONE     = 3'd7
  } reg_idx_e;

  localparam int RET_CNT_W      = 16;
  localparam int RET_UNMASK_BIT = 16;
  localparam int RET_RSTTMR_BIT = 17;
  localparam int STRIDE_LSB     = 3;
  localparam int MAP_BITS       = 6;

endpackage

// File: rtl/ircx_regs.sv
module ircx_regs
  import ircx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              auto_mask_set,
  input  logic [CNT_W-1:0]  credits,
  input  logic [TMR_W-1:0]  elapsed,
  output logic [DATA_W-1:0] rdata,
  output logic [TMR_W-1:0]  delay_lim,
  output logic              quiet,
  output logic              automask_en,
  output logic              mask,
  output logic              ret_valid,
  output logic [RET_CNT_W-1:0] ret_cnt,
  output logic              ret_unmask,
  output logic              ret_rst_tmr
);

  reg_idx_e          idx;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (((addr >> MAP_BITS) != '0) || (addr[STRIDE_LSB-1:0] != '0))
      idx = RI_NONE;
    else
      idx = reg_idx_e'(addr[MAP_BITS-1:STRIDE_LSB]);
  end

  assign ret_valid   = wr && (idx == RI_RETURN);
  assign ret_cnt     = wdata[RET_CNT_W-1:0];
  assign ret_unmask  = ret_valid && wdata[RET_UNMASK_BIT];
  assign ret_rst_tmr = ret_valid && wdata[RET_RSTTMR_BIT];

  always_comb begin
    case (idx)
      RI_DELAY:    rd_mux = DATA_W'(delay_lim);
      RI_ELAPSED:  rd_mux = DATA_W'(elapsed);
      RI_MODE:     rd_mux = DATA_W'(quiet);
      RI_AUTOMASK: rd_mux = DATA_W'(automask_en);
      RI_MASK:     rd_mux = DATA_W'(mask);
      RI_CREDITS:  rd_mux = DATA_W'(credits);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_lim   <= '0;
      quiet       <= 1'b0;
      automask_en <= 1'b0;
      mask        <= 1'b0;
      rdata       <= '0;
    end else begin
      if (wr && idx == RI_DELAY)    delay_lim   <= wdata[TMR_W-1:0];
      if (wr && idx == RI_MODE)     quiet       <= wdata[0];
      if (wr && idx == RI_AUTOMASK) automask_en <= wdata[0];
      if (wr && idx == RI_MASK)     mask        <= wdata[0];
      else if (ret_unmask)          mask        <= 1'b0;
      else if (auto_mask_set)       mask        <= 1'b1;
      if (rd)                       rdata       <= rd_mux;
    end
  end

endmodule

// File: rtl/ircx_credit.sv
module ircx_credit
  import ircx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev,
  input  logic                 ret_valid,
  input  logic [RET_CNT_W-1:0] ret_cnt,
  output logic [CNT_W-1:0]     credits,
  output logic                 cur_zero,
  output logic                 nxt_zero,
  output logic                 pend
);

  localparam int WIDE = ((CNT_W > RET_CNT_W) ? CNT_W : RET_CNT_W) + 1;
  localparam logic [WIDE-1:0] CMAX = WIDE'({CNT_W{1'b1}});

  logic [WIDE-1:0]  sum;
  logic [WIDE-1:0]  sub;
  logic [WIDE-1:0]  diff;
  logic [CNT_W-1:0] c_nxt;

  always_comb begin
    sum  = WIDE'(credits) + WIDE'(ev);
    sub  = ret_valid ? WIDE'(ret_cnt) : '0;
    diff = sum - sub;
    if (sub > sum)
      c_nxt = '0;
    else if (diff > CMAX)
      c_nxt = {CNT_W{1'b1}};
    else
      c_nxt = diff[CNT_W-1:0];
  end

  assign cur_zero = (credits == '0);
  assign nxt_zero = (c_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      credits <= '0;
      pend    <= 1'b0;
    end else begin
      credits <= c_nxt;
      pend    <= !nxt_zero;
    end
  end

endmodule

// File: rtl/ircx_timer.sv
module ircx_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             quiet,
  input  logic             restart_req,
  input  logic             cur_zero,
  input  logic             nxt_zero,
  input  logic [TMR_W-1:0] limit,
  output logic [TMR_W-1:0] elapsed,
  output logic             expired
);

  localparam logic [TMR_W-1:0] TMAX = {TMR_W{1'b1}};

  logic restart;

  assign restart = nxt_zero || cur_zero || restart_req || (quiet && ev);
  assign expired = (elapsed >= limit);

  always_ff @(posedge clk) begin
    if (rst)
      elapsed <= '0;
    else if (restart)
      elapsed <= '0;
    else if (elapsed != TMAX)
      elapsed <= elapsed + 1'b1;
  end

endmodule

// File: rtl/ircx_ctrl.sv
module ircx_ctrl
  import ircx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_pulse,
  output logic              irq_o,
  output logic              pend_o
);

  logic [CNT_W-1:0]     credit_cnt;
  logic [TMR_W-1:0]     elapsed;
  logic [TMR_W-1:0]     delay_lim;
  logic                 quiet, automask_en, mask_q;
  logic                 ret_valid, ret_unmask, ret_rst_tmr;
  logic [RET_CNT_W-1:0] ret_cnt;
  logic                 cur_zero, nxt_zero, expired;
  logic                 fire, auto_mask_set;

  ircx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .auto_mask_set(auto_mask_set), .credits(credit_cnt),
    .elapsed(elapsed), .rdata(reg_rdata), .delay_lim(delay_lim),
    .quiet(quiet), .automask_en(automask_en), .mask(mask_q),
    .ret_valid(ret_valid), .ret_cnt(ret_cnt), .ret_unmask(ret_unmask),
    .ret_rst_tmr(ret_rst_tmr)
  );

  ircx_credit #(.CNT_W(CNT_W)) u_credit (
    .clk(clk), .rst(rst), .ev(evt_pulse), .ret_valid(ret_valid),
    .ret_cnt(ret_cnt), .credits(credit_cnt), .cur_zero(cur_zero),
    .nxt_zero(nxt_zero), .pend(pend_o)
  );

  ircx_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .ev(evt_pulse), .quiet(quiet),
    .restart_req(ret_rst_tmr), .cur_zero(cur_zero), .nxt_zero(nxt_zero),
    .limit(delay_lim), .elapsed(elapsed), .expired(expired)
  );

  assign fire          = !cur_zero && !mask_q && expired;
  assign auto_mask_set = fire && !irq_o && automask_en;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= fire;
  end

endmodule

// File: rtl/ircx_ctrl_chk.sv
module ircx_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ev,
  input logic             wr,
  input logic             rd,
  input logic             irq,
  input logic             pend,
  input logic [CNT_W-1:0] credits,
  input logic             mask,
  input logic             automask,
  input logic             ret_valid
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (credits == CMAX && ev && !ret_valid) |=> (credits == CMAX));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (credits != CMAX && ev && !ret_valid) |=> (credits == $past(credits) + 1'b1));

  a_r5_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && !ev) |=> $stable(credits));

  a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
    (mask || credits == '0) |=> !irq);

  a_r11_automask: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && $past(automask) && !$past(wr)) |-> mask);

  a_r12_pending: assert property (@(posedge clk) disable iff (rst)
    pend == (credits != '0));

endmodule

bind ircx_ctrl ircx_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ev(evt_pulse), .wr(reg_wr), .rd(reg_rd),
  .irq(irq_o), .pend(pend_o), .credits(credit_cnt), .mask(mask_q),
  .automask(automask_en), .ret_valid(ret_valid)
);

// File: tb/sim_ircx_ctrl.sv
`timescale 1ns/1ps
module sim_ircx_ctrl;

  localparam logic [5:0] A_DELAY = 6'h00, A_ELAP = 6'h08, A_MODE = 6'h10,
                         A_AUTO = 6'h18, A_MASK = 6'h20, A_CRED = 6'h28,
                         A_RET = 6'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, evt = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, pend;
  int          nchk = 0, nfail = 0;
  logic        done = 1'b0;
  logic [31:0] d;
  int          n;

  always #2.5 clk = ~clk;

  ircx_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt), .irq_o(irq), .pend_o(pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic pulse();
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic ev_ret(input logic [31:0] v);
    evt = 1'b1; reg_wr = 1'b1; reg_addr = A_RET; reg_wdata = v;
    @(negedge clk);
    evt = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic measure(output int cnt);
    cnt = 0;
    while (!irq && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic clean();
    wr(A_MASK, 32'd1);
    wr(A_RET, 32'h2FFFF);
    wr(A_AUTO, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 pend", pend, 0);
    rd(A_DELAY, d); chk("R1 delay", d, 0);
    rd(A_MODE, d);  chk("R1 mode", d, 0);
    rd(A_AUTO, d);  chk("R1 automask", d, 0);
    rd(A_MASK, d);  chk("R1 mask", d, 0);
    rd(A_CRED, d);  chk("R1 credits", d, 0);
    rd(A_ELAP, d);  chk("R1 elapsed", d, 0);

    // R6 / R7 latency sweep
    for (int mode = 0; mode < 2; mode++) begin
      for (int lim = 0; lim < 7; lim++) begin
        clean();
        wr(A_DELAY, lim); wr(A_MODE, mode); wr(A_MASK, 0);
        chk("R8 idle irq", irq, 0);
        pulse(); measure(n);
        chk(mode == 0 ? "R6 single" : "R7 single", n, lim + 1);
        if (lim >= 2) begin
          clean(); wr(A_MASK, 0);
          pulse(); @(negedge clk); pulse(); measure(n);
          if (mode == 0) chk("R6 second event ignored", n, lim - 1);
          else           chk("R7 restart on event", n, lim + 1);
        end
      end
    end

    // R10 timer restart via return word
    clean(); wr(A_DELAY, 5); wr(A_MODE, 0); wr(A_MASK, 0);
    pulse(); @(negedge clk); @(negedge clk);
    wr(A_RET, 32'h20000); measure(n);
    chk("R10 timer restart", n, 6);

    // R13 elapsed readback
    clean(); wr(A_DELAY, 100); wr(A_MASK, 0);
    pulse(); repeat (3) @(negedge clk);
    rd(A_ELAP, d); chk("R13 elapsed", d, 3);

    // R8 / R5 / R12 / R9 mask behaviour
    clean(); wr(A_DELAY, 0);
    pulse(); repeat (5) @(negedge clk);
    chk("R8 masked irq", irq, 0);
    chk("R12 pend set", pend, 1);
    rd(A_CRED, d); chk("R5 first read", d, 1);
    rd(A_CRED, d); chk("R5 second read", d, 1);
    chk("R12 pend after reads", pend, 1);
    wr(A_MASK, 0); measure(n); chk("R8 unmask latency", n, 1);
    wr(A_MASK, 1); chk("R8 irq one more cycle", irq, 1);
    @(negedge clk); chk("R8 masked drop", irq, 0);
    wr(A_RET, 32'h10000); measure(n); chk("R9 unmask flag", n, 1);
    wr(A_RET, 32'd1);
    chk("R12 pend cleared", pend, 0);
    @(negedge clk); chk("R8 zero credits drop", irq, 0);

    // R11 automatic mask
    clean(); wr(A_DELAY, 0); wr(A_AUTO, 1); wr(A_MASK, 0);
    pulse(); measure(n); chk("R11 rise", n, 1);
    rd(A_MASK, d); chk("R11 mask set", d, 1);
    chk("R11 irq dropped", irq, 0);
    wr(A_RET, 32'h10000); measure(n); chk("R11 rearm", n, 1);
    @(negedge clk); chk("R11 drop again", irq, 0);

    // R3 / R4 credit arithmetic
    clean();
    repeat (7) pulse();
    rd(A_CRED, d); chk("R3 count", d, 7);
    wr(A_RET, 3);  rd(A_CRED, d); chk("R4 subtract", d, 4);
    wr(A_RET, 10); rd(A_CRED, d); chk("R4 clamp zero", d, 0);
    repeat (5) pulse();
    ev_ret(2); rd(A_CRED, d); chk("R4 same cycle", d, 4);
    ev_ret(9); rd(A_CRED, d); chk("R4 same cycle clamp", d, 0);
    evt = 1'b1; repeat (65540) @(negedge clk); evt = 1'b0;
    rd(A_CRED, d); chk("R3 saturate", d, 65535);
    ev_ret(1); rd(A_CRED, d); chk("R4 at max", d, 65535);
    wr(A_RET, 32'hFFFF); rd(A_CRED, d); chk("R4 full return", d, 0);

    // R2 map details
    pulse(); pulse();
    wr(A_CRED, 50); rd(A_CRED, d); chk("R2 credits read-only", d, 2);
    wr(A_ELAP, 77); rd(A_ELAP, d); chk("R2 elapsed not written", d == 77, 0);
    wr(A_DELAY, 32'hABCD1234); rd(A_DELAY, d); chk("R2 delay width", d, 32'h1234);
    wr(A_MODE, 3); rd(A_MODE, d); chk("R2 mode bit", d, 1);
    rd(A_RET, d); chk("R2 return reads zero", d, 0);
    rd(6'h04, d); chk("R2 unaligned zero", d, 0);
    rd(6'h38, d); chk("R2 unmapped zero", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule